// File: doc/BRIEF.md
# Processor Control and Status Register Unit

This block is the control/status register file of a small 32-bit RISC core. The core presents a 12-bit register number, a 32-bit operand, a two-bit write mode and a write enable. The block returns the addressed register's contents combinationally on `rdata`. A write that is allowed takes effect at the next rising clock edge. The write mode selects one of four actions: leave the register alone, OR the operand in, clear the bits that are set in the operand, or replace the whole value.

The unit holds a packed status word, two scratch words and the exception PC and vector words. It also holds the cause and faulting-address words, which the exception path alone updates. Two mailbox words link the core with a host. Three free-running 64-bit counters count clocks, elapsed time and retired instructions. When the core takes an exception, the unit pushes the interrupt-enable and interrupt-mask fields into their saved copies, clears interrupt enable and records the cause, the faulting address and the PC. On exception return it restores enable and mask from the saved copies.

Top module: `csr_unit`

## Requirements
- R1: After reset the status word reads 0x0000_0003, the scratch, EPC, vector, bad-address and to-host words read 0, and the cause word reads 31 (no cause).
- R2: A permitted write combines operand D with the old value V. Mode 0 keeps V. Mode 1 gives V|D. Mode 2 gives V&~D. Mode 3 gives D. The new value is readable from the next cycle.
- R3: The status word reads bit 0 = 1 and bit 1 = 1 always. Bit 2 is interrupt enable and bit 3 is the saved enable. Bits 23:16 are the interrupt mask and bits 31:24 are the saved mask. All other bits read 0, and a write changes only these four fields.
- R4: Writes to the host-to-core mailbox (0x51F), hart ID (0x50B), cause (0x509), bad address (0x503) and all six counter words are ignored.
- R5: Taking an exception copies enable into saved enable, clears enable, copies mask into saved mask, and loads the 5-bit cause (read zero-extended), the bad address and the PC. Interrupt n uses cause 16+n.
- R6: Exception return restores enable from saved enable and mask from saved mask.
- R7: A register write in the same cycle as an exception take is discarded.
- R8: The cycle (low 0xC00, high 0xC80) and time (0xC01/0xC81) counters advance by one every clock.
- R9: The retired-instruction counter (0xC02/0xC82) advances by one in each cycle that `retire` is high and holds otherwise.
- R10: Unmapped addresses read 0. The hart ID word reads the HART_ID parameter, and the to-host word (0x51E) appears on `to_host`.
- R11: With `csr_we` low, no register changes whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register number for read and write |
| csr_wdata | input | 32 | Write operand |
| csr_wmode | input | 2 | 0 none, 1 set, 2 clear, 3 replace |
| csr_we | input | 1 | Write enable |
| rdata | output | 32 | Read data for `csr_addr` |
| retire | input | 1 | One instruction retired this cycle |
| exc_take | input | 1 | Exception taken this cycle |
| exc_cause | input | 5 | Cause code for the exception |
| exc_badaddr | input | 32 | Faulting address |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_return | input | 1 | Return from exception |
| from_host | input | 32 | Host-to-core mailbox value |
| to_host | output | 32 | Core-to-host mailbox value |
| irq_enable | output | 1 | Current interrupt enable |
| irq_mask | output | 8 | Current interrupt mask |
| epc | output | 32 | Exception PC word |
| evec | output | 32 | Exception vector word |

## Verification
The bench writes the status word with all ones through set mode and looks for stray bits in 15:4. A design that stored the whole operand would show them there. It brackets a write to each read-only word with reads, including the counters, which must keep counting past the write rather than load the operand. It drives an exception take and a scratch write in the same cycle to catch a design that lets the squashed write land. It then runs a take, a mask change and a return in sequence, so that a design that restores the wrong copy, or forgets to clear enable, reads back a status word off by one field.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN    = 32;
  localparam int AW      = 12;
  localparam int CAUSE_W = 5;
  localparam int CNT_W   = 64;
  localparam int NUM_CNT = 3;
  localparam int MASK_W  = 8;

  typedef enum logic [1:0] {
    WM_NONE    = 2'd0,
    WM_SET     = 2'd1,
    WM_CLEAR   = 2'd2,
    WM_REPLACE = 2'd3
  } csr_wmode_e;

  typedef struct packed {
    logic [MASK_W-1:0] pim;
    logic [MASK_W-1:0] im;
    logic              pei;
    logic              ei;
  } csr_status_t;

  localparam logic [AW-1:0] A_SCRATCH0 = 12'h500;
  localparam logic [AW-1:0] A_SCRATCH1 = 12'h501;
  localparam logic [AW-1:0] A_EPC      = 12'h502;
  localparam logic [AW-1:0] A_BADADDR  = 12'h503;
  localparam logic [AW-1:0] A_EVEC     = 12'h508;
  localparam logic [AW-1:0] A_CAUSE    = 12'h509;
  localparam logic [AW-1:0] A_STATUS   = 12'h50A;
  localparam logic [AW-1:0] A_HARTID   = 12'h50B;
  localparam logic [AW-1:0] A_TOHOST   = 12'h51E;
  localparam logic [AW-1:0] A_FROMHOST = 12'h51F;
  localparam logic [AW-1:0] A_CNT_LO   = 12'hC00;
  localparam logic [AW-1:0] A_CNT_HI   = 12'hC80;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 5'd31;

  function automatic logic [XLEN-1:0] csr_merge(input logic [1:0] mode,
                                                input logic [XLEN-1:0] old_v,
                                                input logic [XLEN-1:0] opnd);
    case (mode)
      WM_SET:     return old_v | opnd;
      WM_CLEAR:   return old_v & ~opnd;
      WM_REPLACE: return opnd;
      default:    return old_v;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] status_pack(input csr_status_t s);
    return {s.pim, s.im, 12'h000, s.pei, s.ei, 2'b11};
  endfunction

  function automatic csr_status_t status_unpack(input logic [XLEN-1:0] v);
    csr_status_t s;
    s.ei  = v[2];
    s.pei = v[3];
    s.im  = v[23:16];
    s.pim = v[31:24];
    return s;
  endfunction

  function automatic logic is_counter(input logic [AW-1:0] a);
    return (a >= A_CNT_LO && a < A_CNT_LO + NUM_CNT) ||
           (a >= A_CNT_HI && a < A_CNT_HI + NUM_CNT);
  endfunction

  function automatic logic csr_writable(input logic [AW-1:0] a);
    if (is_counter(a)) return 1'b0;
    case (a)
      A_FROMHOST, A_HARTID, A_CAUSE, A_BADADDR: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] cause_zext(input logic [CAUSE_W-1:0] c);
    return {{(XLEN-CAUSE_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/csr_counter.sv
module csr_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (inc) value <= value + {{(W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/csr_data_reg.sv
module csr_data_reg
  import csr_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wmode,
  input  logic [W-1:0] wdata,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (ld_en)  q <= ld_val;
    else if (wr_en)  q <= csr_merge(wmode, q, wdata);
  end
endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wmode,
  input  logic [XLEN-1:0] wdata,
  input  logic            exc_take,
  input  logic            exc_return,
  output csr_status_t     st
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (exc_take) begin
      st.pei <= st.ei;
      st.ei  <= 1'b0;
      st.pim <= st.im;
    end else if (exc_return) begin
      st.ei <= st.pei;
      st.im <= st.pim;
    end else if (wr_en) begin
      st <= status_unpack(csr_merge(wmode, status_pack(st), wdata));
    end
  end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter logic [31:0] HART_ID = 32'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  input  logic [1:0]  csr_wmode,
  input  logic        csr_we,
  output logic [31:0] rdata,
  input  logic        retire,
  input  logic        exc_take,
  input  logic [4:0]  exc_cause,
  input  logic [31:0] exc_badaddr,
  input  logic [31:0] exc_pc,
  input  logic        exc_return,
  input  logic [31:0] from_host,
  output logic [31:0] to_host,
  output logic        irq_enable,
  output logic [7:0]  irq_mask,
  output logic [31:0] epc,
  output logic [31:0] evec
);
  localparam int NUM_RW = 4;
  localparam logic [AW-1:0] RW_ADDR [NUM_RW] = '{A_SCRATCH0, A_SCRATCH1, A_EVEC, A_TOHOST};

  // Named events for the checker
  logic              wr_fire;
  csr_status_t       st;
  logic              st_ei, st_pei;
  logic [MASK_W-1:0] st_im, st_pim;
  logic [CAUSE_W-1:0] cause_q;
  logic [XLEN-1:0]   badaddr_q;
  logic [CNT_W-1:0]  cyc_cnt, ret_cnt;

  logic [XLEN-1:0]   rw_q [NUM_RW];
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_inc;

  assign wr_fire = csr_we && (csr_wmode != WM_NONE) && csr_writable(csr_addr) && !exc_take;

  csr_status_reg u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire && csr_addr == A_STATUS),
    .wmode(csr_wmode), .wdata(csr_wdata),
    .exc_take(exc_take), .exc_return(exc_return),
    .st(st)
  );
  assign st_ei  = st.ei;
  assign st_pei = st.pei;
  assign st_im  = st.im;
  assign st_pim = st.pim;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    csr_data_reg #(.W(XLEN)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_fire && csr_addr == RW_ADDR[g]),
      .wmode(csr_wmode), .wdata(csr_wdata),
      .ld_en(1'b0), .ld_val('0),
      .q(rw_q[g])
    );
  end

  csr_data_reg #(.W(XLEN)) u_epc (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_fire && csr_addr == A_EPC),
    .wmode(csr_wmode), .wdata(csr_wdata),
    .ld_en(exc_take), .ld_val(exc_pc),
    .q(epc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= CAUSE_NONE;
      badaddr_q <= '0;
    end else if (exc_take) begin
      cause_q   <= exc_cause;
      badaddr_q <= exc_badaddr;
    end
  end

  // counter 0 cycle, 1 time, 2 retired instructions
  assign cnt_inc = {retire, 1'b1, 1'b1};
  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    csr_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_inc[c]), .value(cnt_val[c])
    );
  end
  assign cyc_cnt = cnt_val[0];
  assign ret_cnt = cnt_val[2];

  always_comb begin
    rdata = '0;
    case (csr_addr)
      A_STATUS:   rdata = status_pack(st);
      A_HARTID:   rdata = HART_ID;
      A_EPC:      rdata = epc;
      A_CAUSE:    rdata = cause_zext(cause_q);
      A_BADADDR:  rdata = badaddr_q;
      A_FROMHOST: rdata = from_host;
      default:    rdata = '0;
    endcase
    for (int i = 0; i < NUM_RW; i++)
      if (csr_addr == RW_ADDR[i]) rdata = rw_q[i];
    for (int i = 0; i < NUM_CNT; i++) begin
      if (csr_addr == A_CNT_LO + AW'(i)) rdata = cnt_val[i][XLEN-1:0];
      if (csr_addr == A_CNT_HI + AW'(i)) rdata = cnt_val[i][CNT_W-1:XLEN];
    end
  end

  assign to_host    = rw_q[3];
  assign evec       = rw_q[2];
  assign irq_enable = st.ei;
  assign irq_mask   = st.im;
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_take,
  input logic        exc_return,
  input logic        retire,
  input logic [31:0] exc_badaddr,
  input logic [11:0] csr_addr,
  input logic [31:0] rdata,
  input logic        st_ei,
  input logic        st_pei,
  input logic [7:0]  st_im,
  input logic [7:0]  st_pim,
  input logic [4:0]  cause_q,
  input logic [31:0] badaddr_q,
  input logic [63:0] cyc_cnt,
  input logic [63:0] ret_cnt
);
  a_r5_ei_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> !st_ei);
  a_r5_pei_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> st_pei == $past(st_ei));
  a_r5_pim_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> st_pim == $past(st_im));
  a_r5_badaddr_load: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> badaddr_q == $past(exc_badaddr));
  a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_take) |=> (st_ei == $past(st_pei)) && (st_im == $past(st_pim)));
  a_r4_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_take |=> $stable(cause_q));
  a_r8_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cyc_cnt == $past(cyc_cnt) + 64'd1);
  a_r9_instret_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(ret_cnt));
  a_r3_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h50A) |-> (rdata[1:0] == 2'b11 && rdata[15:4] == 12'h000));
endmodule

bind csr_unit csr_unit_chk u_chk (.*);

// File: tb/csr_unit_test.sv
module csr_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [1:0]  csr_wmode;
  logic        csr_we;
  logic [31:0] rdata;
  logic        retire;
  logic        exc_take;
  logic [4:0]  exc_cause;
  logic [31:0] exc_badaddr;
  logic [31:0] exc_pc;
  logic        exc_return;
  logic [31:0] from_host;
  logic [31:0] to_host;
  logic        irq_enable;
  logic [7:0]  irq_mask;
  logic [31:0] epc;
  logic [31:0] evec;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_unit #(.HART_ID(32'h0000_0005)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [1:0] m, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wmode = m; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_wmode = 2'd0;
  endtask

  task automatic take(input logic [4:0] c, input logic [31:0] ba, input logic [31:0] pc);
    @(negedge clk);
    exc_take = 1'b1; exc_cause = c; exc_badaddr = ba; exc_pc = pc;
    @(negedge clk);
    exc_take = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h50A, v); chk("R1 status", v, 32'h0000_0003);
    rd(12'h500, v); chk("R1 scratch0", v, 32'h0);
    rd(12'h509, v); chk("R1 cause", v, 32'd31);
    rd(12'h503, v); chk("R1 badaddr", v, 32'h0);
    chk("R1 to_host", to_host, 32'h0);
    chk("R1 epc", epc, 32'h0);
  endtask

  task automatic t_modes;
    logic [31:0] v;
    wr(12'h500, 2'd3, 32'hF0F0_1234); rd(12'h500, v); chk("R2 replace", v, 32'hF0F0_1234);
    wr(12'h500, 2'd1, 32'h0F00_0001); rd(12'h500, v); chk("R2 set", v, 32'hFFF0_1235);
    wr(12'h500, 2'd2, 32'hFF00_0004); rd(12'h500, v); chk("R2 clear", v, 32'h00F0_1231);
    wr(12'h500, 2'd0, 32'hAAAA_AAAA); rd(12'h500, v); chk("R2 none", v, 32'h00F0_1231);
    wr(12'h501, 2'd3, 32'h1111_2222); rd(12'h501, v); chk("R2 scratch1", v, 32'h1111_2222);
    rd(12'h500, v); chk("R2 scratch0 untouched", v, 32'h00F0_1231);
    wr(12'h508, 2'd3, 32'h0000_0400); chk("R2 evec", evec, 32'h0000_0400);
    @(negedge clk);
    csr_addr = 12'h500; csr_wmode = 2'd3; csr_wdata = 32'h5555_5555; csr_we = 1'b0;
    @(negedge clk);
    csr_wmode = 2'd0;
    rd(12'h500, v); chk("R11 we low", v, 32'h00F0_1231);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(12'h50A, 2'd1, 32'hFFFF_FFFF); rd(12'h50A, v); chk("R3 set all", v, 32'hFFFF_000F);
    chk("R3 irq_mask", {24'h0, irq_mask}, 32'h0000_00FF);
    wr(12'h50A, 2'd3, 32'h0000_0000); rd(12'h50A, v); chk("R3 fixed ones", v, 32'h0000_0003);
  endtask

  task automatic t_readonly;
    logic [31:0] v, v0;
    take(5'd19, 32'h0000_0040, 32'h0000_0200);
    wr(12'h509, 2'd3, 32'hFFFF_FFFF); rd(12'h509, v); chk("R4 cause", v, 32'd19);
    wr(12'h503, 2'd3, 32'h1234_5678); rd(12'h503, v); chk("R4 badaddr", v, 32'h0000_0040);
    wr(12'h50B, 2'd3, 32'hFFFF_FFFF); rd(12'h50B, v); chk("R10 hart id / R4", v, 32'h5);
    wr(12'h51F, 2'd3, 32'h0);         rd(12'h51F, v); chk("R4 from_host", v, 32'h7777_0001);
    wr(12'hC82, 2'd3, 32'hFFFF_FFFF); rd(12'hC82, v); chk("R4 instret hi", v, 32'h0);
    @(negedge clk);
    rd(12'hC00, v0);
    csr_wmode = 2'd3; csr_wdata = 32'h0; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_wmode = 2'd0;
    rd(12'hC00, v); chk("R4 cycle write ignored", v, v0 + 32'd1);
  endtask

  task automatic t_exception;
    logic [31:0] v;
    wr(12'h50A, 2'd3, 32'h3CA5_0004); rd(12'h50A, v); chk("R3 layout", v, 32'h3CA5_0007);
    take(5'd10, 32'hDEAD_BEEF, 32'h0000_0100);
    rd(12'h50A, v); chk("R5 status push", v, 32'hA5A5_000B);
    rd(12'h509, v); chk("R5 cause zext", v, 32'h0000_000A);
    rd(12'h503, v); chk("R5 badaddr", v, 32'hDEAD_BEEF);
    chk("R5 epc", epc, 32'h0000_0100);
    chk("R5 irq off", {31'h0, irq_enable}, 32'h0);
    wr(12'h50A, 2'd2, 32'h00FF_0000); rd(12'h50A, v); chk("R2 clear mask", v, 32'hA500_000B);
    @(negedge clk); exc_return = 1'b1;
    @(negedge clk); exc_return = 1'b0;
    rd(12'h50A, v); chk("R6 restore", v, 32'hA5A5_000F);
    take(5'd16 + 5'd3, 32'h0, 32'h0000_0300);
    rd(12'h509, v); chk("R5 irq cause", v, 32'h0000_0013);
    rd(12'h50A, v); chk("R5 second push", v, 32'hA5A5_000B);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    @(negedge clk);
    exc_take = 1'b1; exc_cause = 5'd7; exc_badaddr = 32'h0; exc_pc = 32'h0000_0500;
    csr_addr = 12'h500; csr_wmode = 2'd3; csr_wdata = 32'hBADB_AD00; csr_we = 1'b1;
    @(negedge clk);
    exc_take = 1'b0; csr_we = 1'b0; csr_wmode = 2'd0;
    rd(12'h500, v); chk("R7 write dropped", v, 32'h00F0_1231);
    chk("R7 epc from exception", epc, 32'h0000_0500);
  endtask

  task automatic t_counters;
    logic [31:0] a, b;
    @(negedge clk);
    rd(12'hC00, a);
    repeat (5) @(negedge clk);
    rd(12'hC00, b); chk("R8 cycle +5", b, a + 32'd5);
    rd(12'hC01, a);
    repeat (3) @(negedge clk);
    rd(12'hC01, b); chk("R8 time +3", b, a + 32'd3);
    rd(12'hC80, b); chk("R8 cycle hi", b, 32'h0);
    rd(12'hC02, a);
    retire = 1'b1;
    repeat (3) @(negedge clk);
    retire = 1'b0;
    repeat (2) @(negedge clk);
    rd(12'hC02, b); chk("R9 instret +3", b, a + 32'd3);
  endtask

  task automatic t_misc;
    logic [31:0] v;
    wr(12'h123, 2'd3, 32'hFFFF_FFFF); rd(12'h123, v); chk("R10 unmapped", v, 32'h0);
    rd(12'hC03, v); chk("R10 unmapped counter slot", v, 32'h0);
    wr(12'h51E, 2'd3, 32'h0000_CAFE); chk("R10 to_host", to_host, 32'h0000_CAFE);
  endtask

  initial begin
    rst_n = 1'b0; csr_addr = '0; csr_wdata = '0; csr_wmode = '0; csr_we = 1'b0;
    retire = 1'b0; exc_take = 1'b0; exc_cause = '0; exc_badaddr = '0; exc_pc = '0;
    exc_return = 1'b0; from_host = 32'h7777_0001;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_modes();
    t_status();
    t_readonly();
    t_exception();
    t_priority();
    t_counters();
    t_misc();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule